// File: doc/BRIEF.md
# Crossbar Slave Port Arbiter

This block decides, cycle by cycle, which of several bus masters may drive one slave port of a multi-master crossbar. Each master presents a hit on this port, a transfer type, a burst-last flag, a flag saying that its previous access to another slave port has not yet completed, a priority value, and a configuration bit that chooses its behaviour during undefined-length bursts. The arbiter chooses a master combinationally. Every active requester that is not chosen sees a wait state. At each clock edge it updates a registered owner and a one-hot grant.

Ownership is sticky. The owner keeps the port until it goes idle or sends its next access somewhere else. When nobody requests, the port stays parked on the last owner. A master whose priority value is strictly lower can take the port only at a completed beat boundary. It cannot do so inside a fixed-length burst, and it cannot do so inside an undefined-length burst whose owner has chosen to hold. A master that still has an access pending at another slave port is never chosen, whatever its priority. This rule avoids deadlock across ports.

Top module: `xbar_port_arb`

## Requirements
- R1: After reset, owner_o is 0, grant_o is one-hot on master 0, and no master waits.
- R2: A master is active when its hit is set and its type is not idle. Types are 2'b00 idle, 2'b01 single, 2'b10 fixed-length burst and 2'b11 undefined-length burst. If the port is parked on an active master, or the owner is not active, the chosen active master sees wait_o low in that same cycle and becomes the owner at the next edge.
- R3: While the owner is active and eligible, any other active master has wait_o high. At most one active master is without a wait in any cycle.
- R4: An active master with its pending-elsewhere flag set always waits and never becomes owner, whatever its priority.
- R5: An active owner keeps the port against requesters with equal or larger priority values.
- R6: If a requester has a strictly smaller priority value than the owner and the owner's beat completes (beat_done_i high) outside a lock, the requester becomes owner at that edge. From then on the former owner waits.
- R7: While the owner's beat is stalled (beat_done_i low), ownership does not change.
- R8: A fixed-length burst beat with burst-last low keeps ownership across the edge, even against a higher-priority requester. Ownership is released after the beat with burst-last high.
- R9: During an undefined-length burst beat with burst-last low, the owner keeps the port if its hold bit is 1. If its hold bit is 0, a higher-priority requester may preempt it.
- R10: Among eligible requesters, the smallest priority value wins. Ties go to the lowest master index.
- R11: With no eligible requester, owner_o and grant_o stay unchanged (parking).
- R12: grant_o is always one-hot and marks master owner_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | N_MST | Per-master access targets this port |
| xfer_type_i | input | 2*N_MST | Per-master transfer type, 2 bits each |
| burst_last_i | input | N_MST | Per-master last beat of burst |
| pend_other_i | input | N_MST | Per-master previous access at another port still pending |
| prio_i | input | PRIO_W*N_MST | Per-master priority, smaller is stronger |
| ulb_hold_i | input | N_MST | Per-master hold ownership during undefined-length bursts |
| beat_done_i | input | 1 | Current address-phase beat completes this cycle |
| grant_o | output | N_MST | Registered one-hot owner |
| wait_o | output | N_MST | Per-master wait state |
| owner_o | output | IDX_W | Registered owner index |

## Verification
The bench builds the block with its defaults: four masters and 3-bit priorities. This is enough for two masters to tie on priority while a third has a stronger or weaker value, and for a blocked top-priority master to sit beside a lower one. Because priorities are inputs, each scenario reprograms them. This reaches preemption, the tie rule, and both settings of the undefined-burst hold bit from whichever owner the previous scenario left parked.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

  typedef enum logic [1:0] {
    XT_IDLE   = 2'b00,
    XT_SINGLE = 2'b01,
    XT_FIXED  = 2'b10,
    XT_UNDEF  = 2'b11
  } xfer_e;

  // A beat of this type keeps the port across the next edge unless it is the last one.
  function automatic logic keeps_port(input logic [1:0] t, input logic hold);
    return (xfer_e'(t) == XT_FIXED) || ((xfer_e'(t) == XT_UNDEF) && hold);
  endfunction

  // Candidate (pa, ia) beats incumbent (pb, ib): smaller priority value, then smaller index.
  function automatic logic outranks(input int unsigned pa, input int unsigned ia,
                                    input int unsigned pb, input int unsigned ib);
    return (pa < pb) || ((pa == pb) && (ia < ib));
  endfunction

endpackage

// File: rtl/xbar_arb_qualify.sv
module xbar_arb_qualify #(
  parameter int N_MST = 4
) (
  input  logic [N_MST-1:0]   hit_i,
  input  logic [2*N_MST-1:0] xfer_type_i,
  input  logic [N_MST-1:0]   pend_other_i,
  output logic [N_MST-1:0]   active_o,
  output logic [N_MST-1:0]   elig_o
);
  import xbar_arb_pkg::*;

  for (genvar m = 0; m < N_MST; m++) begin : g_q
    assign active_o[m] = hit_i[m] && (xfer_e'(xfer_type_i[2*m +: 2]) != XT_IDLE);
    assign elig_o[m]   = active_o[m] && !pend_other_i[m];
  end

endmodule

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0]        elig_i,
  input  logic [PRIO_W*N_MST-1:0] prio_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        best_o,
  output logic [PRIO_W-1:0]       best_prio_o
);
  import xbar_arb_pkg::*;

  always_comb begin
    any_o       = 1'b0;
    best_o      = '0;
    best_prio_o = '0;
    for (int m = 0; m < N_MST; m++) begin
      if (elig_i[m]) begin
        if (!any_o || outranks(int'(prio_i[PRIO_W*m +: PRIO_W]), m,
                               int'(best_prio_o), int'(best_o))) begin
          any_o       = 1'b1;
          best_o      = IDX_W'(m);
          best_prio_o = prio_i[PRIO_W*m +: PRIO_W];
        end
      end
    end
  end

endmodule

// File: rtl/xbar_arb_owner.sv
module xbar_arb_owner #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MST-1:0]        elig_i,
  input  logic [2*N_MST-1:0]      xfer_type_i,
  input  logic [N_MST-1:0]        burst_last_i,
  input  logic [PRIO_W*N_MST-1:0] prio_i,
  input  logic [N_MST-1:0]        ulb_hold_i,
  input  logic                    beat_done_i,
  input  logic                    any_i,
  input  logic [IDX_W-1:0]        best_i,
  input  logic [PRIO_W-1:0]       best_prio_i,
  output logic [IDX_W-1:0]        owner_o,
  output logic [N_MST-1:0]        grant_o,
  output logic                    sel_valid_o,
  output logic [IDX_W-1:0]        sel_idx_o,
  output logic                    own_act_o,
  output logic                    lock_next_o,
  output logic                    preempt_ev_o,
  output logic                    handoff_ev_o
);
  import xbar_arb_pkg::*;

  logic [IDX_W-1:0]  owner_q, owner_d;
  logic [N_MST-1:0]  grant_q, grant_d;
  logic [1:0]        cur_type;
  logic [PRIO_W-1:0] cur_prio;
  logic              better;

  always_comb begin
    cur_type     = xfer_type_i[2*int'(owner_q) +: 2];
    cur_prio     = prio_i[PRIO_W*int'(owner_q) +: PRIO_W];
    own_act_o    = elig_i[owner_q];
    lock_next_o  = own_act_o && keeps_port(cur_type, ulb_hold_i[owner_q])
                   && !burst_last_i[owner_q];
    better       = any_i && (best_prio_i < cur_prio);
    preempt_ev_o = own_act_o && beat_done_i && better && !lock_next_o;
    handoff_ev_o = !own_act_o && any_i;
    sel_valid_o  = own_act_o || any_i;
    sel_idx_o    = own_act_o ? owner_q : best_i;
    owner_d      = (preempt_ev_o || handoff_ev_o) ? best_i : owner_q;
    grant_d      = '0;
    grant_d[owner_d] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      grant_q <= N_MST'(1);
    end else begin
      owner_q <= owner_d;
      grant_q <= grant_d;
    end
  end

  assign owner_o = owner_q;
  assign grant_o = grant_q;

endmodule

// File: rtl/xbar_port_arb.sv
module xbar_port_arb #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MST-1:0]        hit_i,
  input  logic [2*N_MST-1:0]      xfer_type_i,
  input  logic [N_MST-1:0]        burst_last_i,
  input  logic [N_MST-1:0]        pend_other_i,
  input  logic [PRIO_W*N_MST-1:0] prio_i,
  input  logic [N_MST-1:0]        ulb_hold_i,
  input  logic                    beat_done_i,
  output logic [N_MST-1:0]        grant_o,
  output logic [N_MST-1:0]        wait_o,
  output logic [IDX_W-1:0]        owner_o
);

  logic [N_MST-1:0]  active, elig;
  logic              any_req;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;
  logic              sel_valid;
  logic [IDX_W-1:0]  sel_idx;
  logic              own_act, lock_next, preempt_ev, handoff_ev;

  xbar_arb_qualify #(.N_MST(N_MST)) u_qual (
    .hit_i        (hit_i),
    .xfer_type_i  (xfer_type_i),
    .pend_other_i (pend_other_i),
    .active_o     (active),
    .elig_o       (elig)
  );

  xbar_arb_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_pick (
    .elig_i      (elig),
    .prio_i      (prio_i),
    .any_o       (any_req),
    .best_o      (best_idx),
    .best_prio_o (best_prio)
  );

  xbar_arb_owner #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_own (
    .clk          (clk),
    .rst_n        (rst_n),
    .elig_i       (elig),
    .xfer_type_i  (xfer_type_i),
    .burst_last_i (burst_last_i),
    .prio_i       (prio_i),
    .ulb_hold_i   (ulb_hold_i),
    .beat_done_i  (beat_done_i),
    .any_i        (any_req),
    .best_i       (best_idx),
    .best_prio_i  (best_prio),
    .owner_o      (owner_o),
    .grant_o      (grant_o),
    .sel_valid_o  (sel_valid),
    .sel_idx_o    (sel_idx),
    .own_act_o    (own_act),
    .lock_next_o  (lock_next),
    .preempt_ev_o (preempt_ev),
    .handoff_ev_o (handoff_ev)
  );

  for (genvar m = 0; m < N_MST; m++) begin : g_wait
    assign wait_o[m] = active[m] && !(sel_valid && (sel_idx == IDX_W'(m)));
  end

endmodule

// File: rtl/xbar_port_arb_chk.sv
module xbar_port_arb_chk #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_MST-1:0]        hit_i,
  input logic [2*N_MST-1:0]      xfer_type_i,
  input logic [N_MST-1:0]        burst_last_i,
  input logic [N_MST-1:0]        pend_other_i,
  input logic                    beat_done_i,
  input logic [N_MST-1:0]        grant_o,
  input logic [N_MST-1:0]        wait_o,
  input logic [IDX_W-1:0]        owner_o,
  input logic                    preempt_ev
);
  logic [N_MST-1:0] act_c, elig_c;
  logic [1:0]       own_type;
  logic             own_elig;

  always_comb begin
    for (int m = 0; m < N_MST; m++) begin
      act_c[m]  = hit_i[m] && (xfer_type_i[2*m +: 2] != 2'b00);
      elig_c[m] = act_c[m] && !pend_other_i[m];
    end
    own_type = xfer_type_i[2*int'(owner_o) +: 2];
    own_elig = elig_c[owner_o];
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) == 1); // R12
  AST_GRANT_IS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[owner_o]); // R12
  AST_ONE_PROCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_c & ~wait_o) <= 1); // R3
  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (own_elig && !beat_done_i) |=> $stable(owner_o)); // R7
  AST_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_c == '0) |=> $stable(owner_o)); // R11
  AST_FIXED_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (own_elig && own_type == 2'b10 && !burst_last_i[owner_o]) |=> $stable(owner_o)); // R8
  AST_PREEMPT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_ev |=> !$stable(owner_o)); // R6

  for (genvar m = 0; m < N_MST; m++) begin : g_pend
    AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (act_c[m] && pend_other_i[m]) |-> wait_o[m]); // R4
  end

endmodule

bind xbar_port_arb xbar_port_arb_chk #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hit_i        (hit_i),
  .xfer_type_i  (xfer_type_i),
  .burst_last_i (burst_last_i),
  .pend_other_i (pend_other_i),
  .beat_done_i  (beat_done_i),
  .grant_o      (grant_o),
  .wait_o       (wait_o),
  .owner_o      (owner_o),
  .preempt_ev   (preempt_ev)
);

// File: tb/tb_xbar_port_arb.sv
module tb_xbar_port_arb;
  localparam int N = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  hit = '0;
  logic [2*N-1:0] xtype = '0;
  logic [N-1:0]  blast = '0;
  logic [N-1:0]  pend = '0;
  logic [PW*N-1:0] prio = '0;
  logic [N-1:0]  hold = '0;
  logic          bdone = 1'b1;
  logic [N-1:0]  grant, waitv;
  logic [1:0]    owner;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  xbar_port_arb #(.N_MST(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .xfer_type_i(xtype),
    .burst_last_i(blast), .pend_other_i(pend), .prio_i(prio),
    .ulb_hold_i(hold), .beat_done_i(bdone),
    .grant_o(grant), .wait_o(waitv), .owner_o(owner)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic drive(input int m, input logic [1:0] t, input logic last);
    hit[m] = (t != 2'b00);
    xtype[2*m +: 2] = t;
    blast[m] = last;
  endtask

  task automatic set_prio(input int m, input int p);
    prio[PW*m +: PW] = PW'(p);
  endtask

  task automatic clear_all();
    hit = '0; xtype = '0; blast = '0; pend = '0; hold = '0; bdone = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "owner", int'(owner), 0);
    chk("R1", "grant", int'(grant), 1);
    chk("R1", "wait", int'(waitv), 0);
  endtask

  task automatic t_free_and_park();
    drive(2, 2'b01, 1'b0); settle();
    chk("R2", "wait2 free port", int'(waitv[2]), 0);
    step();
    chk("R2", "owner after free grant", int'(owner), 2);
    chk("R12", "grant one-hot", int'(grant), 4);
    clear_all(); step();
    chk("R11", "parked owner", int'(owner), 2);
    drive(2, 2'b01, 1'b0); settle();
    chk("R2", "wait2 parked", int'(waitv[2]), 0);
    step(); clear_all();
  endtask

  task automatic t_busy();
    set_prio(2, 4); set_prio(3, 6);
    drive(2, 2'b01, 1'b0); drive(3, 2'b01, 1'b0); settle();
    chk("R3", "wait3 busy", int'(waitv[3]), 1);
    chk("R3", "wait2 owner", int'(waitv[2]), 0);
    step();
    chk("R5", "owner kept", int'(owner), 2);
    drive(2, 2'b00, 1'b0); settle();
    chk("R2", "wait3 after owner idles", int'(waitv[3]), 0);
    step();
    chk("R2", "owner handed", int'(owner), 3);
    clear_all();
  endtask

  task automatic t_pending();
    set_prio(1, 1); set_prio(0, 4);
    drive(1, 2'b01, 1'b0); pend[1] = 1'b1;
    drive(0, 2'b01, 1'b0); settle();
    chk("R4", "wait1 pending", int'(waitv[1]), 1);
    chk("R4", "wait0", int'(waitv[0]), 0);
    step();
    chk("R4", "owner not pending master", int'(owner), 0);
    clear_all();
  endtask

  task automatic t_preempt();
    set_prio(0, 4); set_prio(1, 2);
    drive(0, 2'b01, 1'b0); drive(1, 2'b01, 1'b0); bdone = 1'b0; settle();
    chk("R3", "wait1 behind owner", int'(waitv[1]), 1);
    step();
    chk("R7", "owner during stall", int'(owner), 0);
    bdone = 1'b1; step();
    chk("R6", "owner after preempt", int'(owner), 1);
    settle();
    chk("R6", "preempted waits", int'(waitv[0]), 1);
    chk("R6", "winner no wait", int'(waitv[1]), 0);
    clear_all();
  endtask

  task automatic t_fixed();
    set_prio(1, 2); set_prio(2, 0);
    drive(1, 2'b10, 1'b0); drive(2, 2'b01, 1'b0); settle();
    chk("R8", "wait2 during fixed burst", int'(waitv[2]), 1);
    step();
    chk("R8", "owner mid fixed burst", int'(owner), 1);
    drive(1, 2'b10, 1'b1); step();
    chk("R8", "owner after last beat", int'(owner), 2);
    clear_all();
  endtask

  task automatic t_undef();
    set_prio(2, 5); set_prio(0, 1);
    drive(2, 2'b11, 1'b0); hold[2] = 1'b1; drive(0, 2'b01, 1'b0); settle();
    chk("R9", "wait0 held burst", int'(waitv[0]), 1);
    step();
    chk("R9", "owner with hold", int'(owner), 2);
    hold[2] = 1'b0; step();
    chk("R9", "owner without hold", int'(owner), 0);
    clear_all();
  endtask

  task automatic t_ties();
    set_prio(0, 4); set_prio(1, 3); set_prio(3, 3);
    drive(1, 2'b01, 1'b0); drive(3, 2'b01, 1'b0); settle();
    chk("R10", "wait1 tie", int'(waitv[1]), 0);
    chk("R10", "wait3 tie", int'(waitv[3]), 1);
    step();
    chk("R10", "tie owner", int'(owner), 1);
    drive(3, 2'b00, 1'b0); set_prio(0, 3); drive(0, 2'b01, 1'b0); step();
    chk("R5", "equal prio no preempt", int'(owner), 1);
    clear_all(); step();
    set_prio(3, 2); set_prio(2, 5);
    drive(3, 2'b01, 1'b0); drive(2, 2'b01, 1'b0); settle();
    chk("R10", "wait3 stronger", int'(waitv[3]), 0);
    chk("R10", "wait2 weaker", int'(waitv[2]), 1);
    step();
    chk("R10", "owner stronger", int'(owner), 3);
    chk("R12", "grant matches owner", int'(grant), 8);
    clear_all();
  endtask

  initial begin
    for (int m = 0; m < N; m++) set_prio(m, 4);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    t_reset();
    step();
    t_free_and_park();
    t_busy();
    t_pending();
    t_preempt();
    t_fixed();
    t_undef();
    t_ties();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule